// File: doc/BRIEF.md
# Coprocessor Handshake Sequencer

This block sits on the core side of a coprocessor link. When the core starts a coprocessor instruction, the block runs the whole handshake. It issues a first-phase request that carries the instruction. It then polls while the coprocessor reports busy, placing one idle cycle between polls. In that idle cycle it looks for an interrupt that is pending and unmasked. If it finds one, it tells the coprocessor and abandons the transfer. If the coprocessor refuses the instruction, the block raises an undefined-instruction trap.

Four kinds of transfer are supported. Two are single register moves, one towards the coprocessor and one back to the core. The other two are multi-word loads and stores. For a load or store the coprocessor decides the burst length one word at a time: each data word is followed by a further word for as long as the coprocessor answers "increment". Memory is a simple port. A request is held until it is acknowledged, and the abort flag is valid in the acknowledge cycle. Each instruction ends with a one-cycle done pulse, a status code and an interrupt cause. A programmable limit on the number of busy polls keeps a hung coprocessor from stalling the core forever.

Top module: `cp_handshake_seq`

## Requirements
- R1: `start` is accepted only while `busy` is low. The next cycle shows `cp_req` high with phase FIRST (0) and carries `instr` on `cp_instr`. A `start` pulse while `busy` is high has no effect on the running sequence.
- R2: The response on `cp_resp` is encoded as busy 0, cant 1, ready 2, increment 3. It is read in every cycle in which `cp_req` is high with phase FIRST, BUSY or DATA. A busy answer to FIRST or BUSY (1) is followed by exactly one cycle with `cp_req` low, and then by a BUSY-phase request.
- R3: In the idle cycle the block takes an interrupt by fixed priority. `rst_req` comes first. Next is `fiq_req` with `fiq_mask` low, and then `irq_req` with `irq_mask` low. A masked request is never taken. The cause is reported as none 0, reset 1, fast 2, normal 3.
- R4: A taken interrupt produces one request with phase INTERRUPT (2). In the following cycle `done` is high with status interrupted (1) and the cause on `int_cause`.
- R5: A cant answer ends the instruction with status undefined (2) and `undef_trap` high with `done`. For a coprocessor-to-core move (op 1), `result` then holds the captured `flags_in` in its top FLAG_W bits and zeros below.
- R6: The idle cycle that makes TIMEOUT idle cycles in one instruction ends the instruction when no interrupt is taken in it. The end comes with `timeout_err`, `undef_trap` and status undefined.
- R7: For a load (op 2) or store (op 3), a ready or increment answer to FIRST/BUSY is followed by one TRANSFER (3) request. DATA (4) cycles follow, with `mem_req` high and the first address equal to `addr_in`. Each increment answer steps the address by 4 for another word. Any other answer ends with status complete (0).
- R8: `base_wb` pulses once, in the acknowledge cycle of the first data word, only when bit 21 of the instruction is set.
- R9: A `mem_abort` on any acknowledged data word lets the burst run to its end. It then reports status aborted (3) with `dabort_trap` high.
- R10: `done` is a single-cycle pulse. For op 0 and op 1, a ready answer ends with status complete. For op 1, `result` then holds `cp_rdata` from the ready cycle.
- R11: For a core-to-coprocessor move (op 0), `cp_wdata` carries `src_data` during FIRST and BUSY requests.
- R12: During a load, `cp_wdata` passes `mem_rdata` to the coprocessor. During a store, `mem_wdata` carries `cp_rdata` and `mem_we` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a coprocessor instruction |
| op | input | 2 | Transfer kind: 0 to-cp, 1 from-cp, 2 load, 3 store |
| instr | input | 32 | Instruction word |
| src_data | input | DW | Core register value for op 0 |
| flags_in | input | FLAG_W | Condition flags captured at start |
| addr_in | input | AW | First memory address of a burst |
| busy | output | 1 | Sequence in progress |
| cp_req | output | 1 | Request to the coprocessor |
| cp_phase | output | 3 | Phase: 0 first, 1 busy, 2 interrupt, 3 transfer, 4 data |
| cp_instr | output | 32 | Instruction held for the coprocessor |
| cp_wdata | output | DW | Data towards the coprocessor |
| cp_resp | input | 2 | Coprocessor answer |
| cp_rdata | input | DW | Data from the coprocessor |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | DW | Memory read data |
| mem_abort | input | 1 | Memory abort, valid with acknowledge |
| rst_req | input | 1 | Pending reset |
| fiq_req | input | 1 | Fast interrupt request |
| fiq_mask | input | 1 | Fast interrupt disabled |
| irq_req | input | 1 | Normal interrupt request |
| irq_mask | input | 1 | Normal interrupt disabled |
| base_wb | output | 1 | Base register update strobe |
| done | output | 1 | Instruction finished |
| status | output | 2 | 0 complete, 1 interrupted, 2 undefined, 3 aborted |
| int_cause | output | 2 | Interrupt cause |
| result | output | DW | Value for the core after op 1 |
| undef_trap | output | 1 | Undefined-instruction trap |
| dabort_trap | output | 1 | Data-abort trap |
| timeout_err | output | 1 | Busy wait limit reached |

## Verification
The assertions assume three things about the inputs. `cp_resp` is a valid code in every cycle in which a response is read. The memory acknowledges in the same cycle it is asked. The interrupt levels change only between instructions. The bench keeps to these conditions: the coprocessor answers come from a per-test script indexed by the number of responses consumed, the memory model ties the acknowledge to the request, and the interrupt inputs are set before each start and held until the next test.

// File: rtl/cphs_pkg.sv
package cphs_pkg;
  typedef enum logic [1:0] {RSP_BUSY = 2'd0, RSP_CANT = 2'd1, RSP_READY = 2'd2, RSP_INC = 2'd3} resp_e;
  typedef enum logic [2:0] {PH_FIRST = 3'd0, PH_BUSY = 3'd1, PH_INTR = 3'd2, PH_XFER = 3'd3, PH_DATA = 3'd4} phase_e;
  typedef enum logic [1:0] {OP_TO_CP = 2'd0, OP_FROM_CP = 2'd1, OP_LOAD = 2'd2, OP_STORE = 2'd3} op_e;
  typedef enum logic [1:0] {ST_DONE = 2'd0, ST_INTR = 2'd1, ST_UNDEF = 2'd2, ST_ABORT = 2'd3} status_e;
  typedef enum logic [1:0] {IC_NONE = 2'd0, IC_RESET = 2'd1, IC_FAST = 2'd2, IC_NORMAL = 2'd3} cause_e;
  typedef enum logic [2:0] {S_IDLE, S_FIRST, S_WAIT, S_BUSY, S_INTR, S_XFER, S_DATA} state_e;
  localparam int unsigned WB_BIT = 21;
endpackage

// File: rtl/cphs_int_arb.sv
module cphs_int_arb
  import cphs_pkg::*;
(
  input  logic   rst_req,
  input  logic   fiq_req,
  input  logic   fiq_mask,
  input  logic   irq_req,
  input  logic   irq_mask,
  output logic   take,
  output cause_e cause
);
  // fixed order: reset, then unmasked fast, then unmasked normal
  always_comb begin
    if (rst_req)                   cause = IC_RESET;
    else if (fiq_req && !fiq_mask) cause = IC_FAST;
    else if (irq_req && !irq_mask) cause = IC_NORMAL;
    else                           cause = IC_NONE;
  end
  assign take = (cause != IC_NONE);
endmodule

// File: rtl/cphs_wait_timer.sv
module cphs_wait_timer #(
  parameter int TIMEOUT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  output logic expired
);
  localparam int CW = $clog2(TIMEOUT + 1);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign expired = tick && (cnt_q == CW'(TIMEOUT - 1));
  assign cnt_en  = clr || (tick && !expired);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (tick) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  a_r6_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(TIMEOUT - 1));
endmodule

// File: rtl/cphs_addr_step.sv
module cphs_addr_step #(
  parameter int AW   = 32,
  parameter int STEP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] addr_d;
  logic          addr_en;

  assign addr_en = load || step;
  always_comb addr_d = load ? addr_in : addr + AW'(STEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr <= '0;
    else if (addr_en) addr <= addr_d;
  end
endmodule

// File: rtl/cp_handshake_seq.sv
module cp_handshake_seq
  import cphs_pkg::*;
#(
  parameter int AW      = 32,
  parameter int DW      = 32,
  parameter int FLAG_W  = 4,
  parameter int TIMEOUT = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        op,
  input  logic [31:0]       instr,
  input  logic [DW-1:0]     src_data,
  input  logic [FLAG_W-1:0] flags_in,
  input  logic [AW-1:0]     addr_in,
  output logic              busy,
  output logic              cp_req,
  output logic [2:0]        cp_phase,
  output logic [31:0]       cp_instr,
  output logic [DW-1:0]     cp_wdata,
  input  logic [1:0]        cp_resp,
  input  logic [DW-1:0]     cp_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic              mem_ack,
  input  logic [DW-1:0]     mem_rdata,
  input  logic              mem_abort,
  input  logic              rst_req,
  input  logic              fiq_req,
  input  logic              fiq_mask,
  input  logic              irq_req,
  input  logic              irq_mask,
  output logic              base_wb,
  output logic              done,
  output logic [1:0]        status,
  output logic [1:0]        int_cause,
  output logic [DW-1:0]     result,
  output logic              undef_trap,
  output logic              dabort_trap,
  output logic              timeout_err
);
  localparam int WORD_BYTES = 4;
  localparam int LOW_W      = DW - FLAG_W;

  // reset: asserted asynchronously, released through two flops
  logic rsync_q1, rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q1 <= 1'b0;
      rst_n_s  <= 1'b0;
    end else begin
      rsync_q1 <= 1'b1;
      rst_n_s  <= rsync_q1;
    end
  end

  state_e            state_q, state_d;
  op_e               op_q;
  logic [31:0]       instr_q;
  logic [DW-1:0]     src_q, result_q, result_d;
  logic [FLAG_W-1:0] flags_q;
  logic              first_q, first_d, abort_q, abort_d;
  logic              done_q, undef_q, dabort_q, tmo_q;
  status_e           status_q, fin_st;
  cause_e            cause_q, arb_cause;
  logic              accept, fin, fin_tmo, res_en, step, tick, take, expired, wb;
  resp_e             resp;

  assign resp   = resp_e'(cp_resp);
  assign accept = (state_q == S_IDLE) && start;

  cphs_int_arb u_arb (
    .rst_req(rst_req), .fiq_req(fiq_req), .fiq_mask(fiq_mask),
    .irq_req(irq_req), .irq_mask(irq_mask), .take(take), .cause(arb_cause)
  );

  cphs_wait_timer #(.TIMEOUT(TIMEOUT)) u_timer (
    .clk(clk), .rst_n(rst_n_s), .clr(accept), .tick(tick), .expired(expired)
  );

  cphs_addr_step #(.AW(AW), .STEP(WORD_BYTES)) u_addr (
    .clk(clk), .rst_n(rst_n_s), .load(accept), .step(step),
    .addr_in(addr_in), .addr(mem_addr)
  );

  // next-state logic
  always_comb begin
    state_d  = state_q;
    fin      = 1'b0;
    fin_st   = ST_DONE;
    fin_tmo  = 1'b0;
    res_en   = 1'b0;
    result_d = result_q;
    first_d  = first_q;
    abort_d  = abort_q;
    step     = 1'b0;
    tick     = 1'b0;
    wb       = 1'b0;
    case (state_q)
      S_IDLE: if (start) state_d = S_FIRST;
      S_FIRST, S_BUSY: begin
        case (resp)
          RSP_BUSY: state_d = S_WAIT;
          RSP_CANT: begin
            fin    = 1'b1;
            fin_st = ST_UNDEF;
            if (op_q == OP_FROM_CP) begin
              res_en   = 1'b1;
              result_d = {flags_q, {LOW_W{1'b0}}};
            end
          end
          default: begin
            if (op_q == OP_TO_CP || op_q == OP_FROM_CP) begin
              fin = 1'b1;
              if (op_q == OP_FROM_CP) begin
                res_en   = 1'b1;
                result_d = cp_rdata;
              end
            end else begin
              state_d = S_XFER;
            end
          end
        endcase
      end
      S_WAIT: begin
        tick = 1'b1;
        if (take) state_d = S_INTR;
        else if (expired) begin
          fin     = 1'b1;
          fin_st  = ST_UNDEF;
          fin_tmo = 1'b1;
        end else state_d = S_BUSY;
      end
      S_INTR: begin
        fin    = 1'b1;
        fin_st = ST_INTR;
      end
      S_XFER: begin
        state_d = S_DATA;
        first_d = 1'b1;
        abort_d = 1'b0;
      end
      S_DATA: begin
        if (mem_ack) begin
          wb      = first_q && instr_q[WB_BIT];
          first_d = 1'b0;
          abort_d = abort_q || mem_abort;
          if (resp == RSP_INC) step = 1'b1;
          else begin
            fin    = 1'b1;
            fin_st = (abort_q || mem_abort) ? ST_ABORT : ST_DONE;
          end
        end
      end
      default: state_d = S_IDLE;
    endcase
    if (fin) state_d = S_IDLE;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q  <= S_IDLE;
      op_q     <= OP_TO_CP;
      instr_q  <= '0;
      src_q    <= '0;
      flags_q  <= '0;
      result_q <= '0;
      first_q  <= 1'b0;
      abort_q  <= 1'b0;
      done_q   <= 1'b0;
      undef_q  <= 1'b0;
      dabort_q <= 1'b0;
      tmo_q    <= 1'b0;
      status_q <= ST_DONE;
      cause_q  <= IC_NONE;
    end else begin
      state_q  <= state_d;
      first_q  <= first_d;
      abort_q  <= abort_d;
      done_q   <= fin;
      undef_q  <= fin && (fin_st == ST_UNDEF);
      dabort_q <= fin && (fin_st == ST_ABORT);
      tmo_q    <= fin_tmo;
      if (accept) begin
        op_q    <= op_e'(op);
        instr_q <= instr;
        src_q   <= src_data;
        flags_q <= flags_in;
      end
      if (res_en) result_q <= result_d;
      if (fin)    status_q <= fin_st;
      if (accept)                           cause_q <= IC_NONE;
      else if (state_q == S_WAIT && take)   cause_q <= arb_cause;
    end
  end

  // outputs
  always_comb begin
    cp_req   = 1'b1;
    cp_phase = 3'(PH_FIRST);
    case (state_q)
      S_FIRST: cp_phase = 3'(PH_FIRST);
      S_BUSY:  cp_phase = 3'(PH_BUSY);
      S_INTR:  cp_phase = 3'(PH_INTR);
      S_XFER:  cp_phase = 3'(PH_XFER);
      S_DATA:  cp_phase = 3'(PH_DATA);
      default: cp_req   = 1'b0;
    endcase
  end

  assign busy        = (state_q != S_IDLE);
  assign mem_req     = (state_q == S_DATA);
  assign mem_we      = mem_req && (op_q == OP_STORE);
  assign mem_wdata   = cp_rdata;
  assign cp_wdata    = (op_q == OP_LOAD) ? mem_rdata : src_q;
  assign cp_instr    = instr_q;
  assign base_wb     = wb;
  assign done        = done_q;
  assign status      = 2'(status_q);
  assign int_cause   = 2'(cause_q);
  assign result      = result_q;
  assign undef_trap  = undef_q;
  assign dabort_trap = dabort_q;
  assign timeout_err = tmo_q;

  // assertions
  a_r1_first_after_start: assert property (@(posedge clk) disable iff (!rst_n_s)
    (start && !busy) |=> (cp_req && cp_phase == 3'(PH_FIRST)));
  a_r2_idle_gap: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cp_req && (cp_phase == 3'(PH_FIRST) || cp_phase == 3'(PH_BUSY)) && cp_resp == 2'(RSP_BUSY))
      |=> !cp_req);
  a_r3_reset_wins: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state_q == S_WAIT && rst_req) |=> (cp_req && cp_phase == 3'(PH_INTR)));
  a_r4_intr_ends: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cp_req && cp_phase == 3'(PH_INTR)) |=> (done && status == 2'(ST_INTR) && int_cause != 2'(IC_NONE)));
  a_r5_undef_status: assert property (@(posedge clk) disable iff (!rst_n_s)
    undef_trap |-> (done && status == 2'(ST_UNDEF)));
  a_r7_addr_step: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mem_req && mem_ack && cp_resp == 2'(RSP_INC)) |=> (mem_req && mem_addr == $past(mem_addr) + AW'(WORD_BYTES)));
  a_r8_wb_once: assert property (@(posedge clk) disable iff (!rst_n_s)
    base_wb |=> !base_wb);
  a_r9_abort_status: assert property (@(posedge clk) disable iff (!rst_n_s)
    dabort_trap |-> (done && status == 2'(ST_ABORT)));
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n_s)
    done |=> !done);
endmodule

// File: tb/tb_cp_handshake_seq.sv
module tb_cp_handshake_seq;
  localparam int TMO = 5;
  localparam logic [31:0] RMASK = 32'hA5A5_0000;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, start, cp_req, busy, mem_req, mem_we, mem_ack, mem_abort, base_wb, done;
  logic undef_trap, dabort_trap, timeout_err, rst_req, fiq_req, fiq_mask, irq_req, irq_mask;
  logic [1:0] op, cp_resp, status, int_cause;
  logic [2:0] cp_phase;
  logic [31:0] instr, src_data, addr_in, cp_instr, cp_wdata, cp_rdata, mem_addr, mem_wdata, mem_rdata, result;
  logic [3:0] flags_in;

  cp_handshake_seq #(.TIMEOUT(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .instr(instr), .src_data(src_data),
    .flags_in(flags_in), .addr_in(addr_in), .busy(busy), .cp_req(cp_req), .cp_phase(cp_phase),
    .cp_instr(cp_instr), .cp_wdata(cp_wdata), .cp_resp(cp_resp), .cp_rdata(cp_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_abort(mem_abort), .rst_req(rst_req),
    .fiq_req(fiq_req), .fiq_mask(fiq_mask), .irq_req(irq_req), .irq_mask(irq_mask),
    .base_wb(base_wb), .done(done), .status(status), .int_cause(int_cause), .result(result),
    .undef_trap(undef_trap), .dabort_trap(dabort_trap), .timeout_err(timeout_err)
  );

  // scripted coprocessor and memory
  logic [1:0] scr [16];
  int ri, wi, abort_idx;
  logic clr_cnt;
  assign cp_resp   = scr[ri % 16];
  assign mem_ack   = mem_req;
  assign mem_abort = mem_req && (wi == abort_idx);
  assign mem_rdata = mem_addr ^ RMASK;

  always @(posedge clk) begin
    if (clr_cnt) begin
      ri <= 0;
      wi <= 0;
    end else begin
      if (cp_req && (cp_phase == 3'd0 || cp_phase == 3'd1 || (cp_phase == 3'd4 && mem_ack))) ri <= ri + 1;
      if (mem_req && mem_ack) wi <= wi + 1;
    end
  end

  typedef struct {
    bit cpreq; int ph; bit memreq; bit we; logic [31:0] addr; bit wb;
    bit dn; int st; bit und; bit dab; bit tmo; int cause;
    bit chkres; logic [31:0] res; int dk; logic [31:0] dval;
  } exp_t;
  exp_t q[$];

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic exp_t blank();
    exp_t e;
    e.cpreq = 0; e.ph = 0; e.memreq = 0; e.we = 0; e.addr = 0; e.wb = 0;
    e.dn = 0; e.st = 0; e.und = 0; e.dab = 0; e.tmo = 0; e.cause = 0;
    e.chkres = 0; e.res = 0; e.dk = 0; e.dval = 0;
    return e;
  endfunction

  function automatic int pending();
    if (rst_req) return 1;
    if (fiq_req && !fiq_mask) return 2;
    if (irq_req && !irq_mask) return 3;
    return 0;
  endfunction

  // behavioural reference: expected per-cycle outputs from the script
  task automatic build();
    int r = 0, w = 0, wd = 0, ph = 0;
    bit fin = 0, ab = 0;
    logic [31:0] a = addr_in;
    exp_t e;
    q.delete();
    while (!fin) begin
      e = blank(); e.cpreq = 1; e.ph = ph;
      if (op == 2'd0) begin e.dk = 1; e.dval = src_data; end
      q.push_back(e);
      case (scr[r])
        2'd0: begin
          r++; w++;
          q.push_back(blank());
          if (pending() != 0) begin
            e = blank(); e.cpreq = 1; e.ph = 2; q.push_back(e);
            e = blank(); e.dn = 1; e.st = 1; e.cause = pending(); q.push_back(e);
            fin = 1;
          end else if (w == TMO) begin
            e = blank(); e.dn = 1; e.st = 2; e.und = 1; e.tmo = 1; q.push_back(e);
            fin = 1;
          end else ph = 1;
        end
        2'd1: begin
          e = blank(); e.dn = 1; e.st = 2; e.und = 1;
          if (op == 2'd1) begin e.chkres = 1; e.res = {flags_in, 28'd0}; end
          q.push_back(e); fin = 1;
        end
        default: begin
          r++;
          if (op < 2'd2) begin
            e = blank(); e.dn = 1; e.st = 0;
            if (op == 2'd1) begin e.chkres = 1; e.res = cp_rdata; end
            q.push_back(e);
          end else begin
            e = blank(); e.cpreq = 1; e.ph = 3; q.push_back(e);
            forever begin
              e = blank(); e.cpreq = 1; e.ph = 4; e.memreq = 1; e.we = (op == 2'd3);
              e.addr = a; e.wb = (wd == 0) && instr[21];
              if (op == 2'd2) begin e.dk = 1; e.dval = a ^ RMASK; end
              else begin e.dk = 2; e.dval = cp_rdata; end
              q.push_back(e);
              if (wd == abort_idx) ab = 1;
              wd++;
              if (scr[r] == 2'd3) begin r++; a = a + 4; end
              else break;
            end
            e = blank(); e.dn = 1; e.st = ab ? 3 : 0; e.dab = ab; q.push_back(e);
          end
          fin = 1;
        end
      endcase
    end
  endtask

  task automatic run(string tag, bit restart);
    int k = 0;
    build();
    @(negedge clk);
    start = 1; clr_cnt = 1;
    @(negedge clk);
    start = 0; clr_cnt = 0;
    while (q.size() > 0) begin
      exp_t e = q.pop_front();
      chk(cp_req == e.cpreq, tag, "cp_req", 32'(cp_req), 32'(e.cpreq));
      if (e.cpreq) chk(cp_phase == 3'(e.ph), tag, "cp_phase", 32'(cp_phase), 32'(e.ph));
      if (e.ph == 0 && e.cpreq) chk(cp_instr == instr, tag, "cp_instr", cp_instr, instr);
      chk(mem_req == e.memreq, tag, "mem_req", 32'(mem_req), 32'(e.memreq));
      if (e.memreq) begin
        chk(mem_addr == e.addr, tag, "mem_addr", mem_addr, e.addr);
        chk(mem_we == e.we, tag, "mem_we", 32'(mem_we), 32'(e.we));
      end
      chk(base_wb == e.wb, tag, "base_wb", 32'(base_wb), 32'(e.wb));
      chk(done == e.dn, tag, "done", 32'(done), 32'(e.dn));
      if (e.dn) begin
        chk(status == 2'(e.st), tag, "status", 32'(status), 32'(e.st));
        chk(undef_trap == e.und, tag, "undef_trap", 32'(undef_trap), 32'(e.und));
        chk(dabort_trap == e.dab, tag, "dabort_trap", 32'(dabort_trap), 32'(e.dab));
        chk(timeout_err == e.tmo, tag, "timeout_err", 32'(timeout_err), 32'(e.tmo));
        chk(int_cause == 2'(e.cause), tag, "int_cause", 32'(int_cause), 32'(e.cause));
        if (e.chkres) chk(result == e.res, tag, "result", result, e.res);
      end
      if (e.dk == 1) chk(cp_wdata == e.dval, tag, "cp_wdata", cp_wdata, e.dval);
      if (e.dk == 2) chk(mem_wdata == e.dval, tag, "mem_wdata", mem_wdata, e.dval);
      k++;
      start = (restart && k == 2);
      @(negedge clk);
      start = 0;
    end
    chk(!busy && !done && !cp_req, tag, "idle after done", {29'd0, busy, done, cp_req}, 32'd0);
  endtask

  task automatic setup(logic [1:0] o, logic b21, logic [3:0] fl, int abi);
    op = o; instr = 32'h0E00_0A10 | (32'(b21) << 21); flags_in = fl; abort_idx = abi;
    rst_req = 0; fiq_req = 0; fiq_mask = 0; irq_req = 0; irq_mask = 0;
    for (int i = 0; i < 16; i++) scr[i] = 2'd2;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 0; start = 0; clr_cnt = 1; op = 0; instr = 0; src_data = 32'h1234_5678;
    flags_in = 0; addr_in = 32'h100; cp_rdata = 32'hCAFE_0001; abort_idx = 99;
    rst_req = 0; fiq_req = 0; fiq_mask = 0; irq_req = 0; irq_mask = 0;
    for (int i = 0; i < 16; i++) scr[i] = 2'd2;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    clr_cnt = 0;
    // R1 R10: reset state
    chk(!busy && !done && !cp_req && !mem_req && !base_wb, "R1 R10", "reset state",
        {27'd0, busy, done, cp_req, mem_req, base_wb}, 32'd0);

    // R2 R11: move to coprocessor, immediate ready
    setup(2'd0, 0, 4'h0, 99); src_data = 32'h5A5A_0F0F;
    run("R2 R11 R10", 0);
    // R2 R10: move from coprocessor after two busy polls
    setup(2'd1, 0, 4'h0, 99); scr[0] = 2'd0; scr[1] = 2'd0; cp_rdata = 32'h0BAD_F00D;
    run("R2 R10", 0);
    // R5: refusal after busy on a read returns the flags
    setup(2'd1, 0, 4'hA, 99); scr[0] = 2'd0; scr[1] = 2'd1;
    run("R5", 0);
    // R3 R4: unmasked normal interrupt
    setup(2'd0, 0, 4'h0, 99); scr[0] = 2'd0; irq_req = 1;
    run("R3 R4", 0);
    // R3: all three pending, reset wins
    setup(2'd1, 0, 4'h0, 99); scr[0] = 2'd0; rst_req = 1; fiq_req = 1; irq_req = 1;
    run("R3 R4", 0);
    // R3: fast over normal
    setup(2'd1, 0, 4'h0, 99); scr[0] = 2'd0; fiq_req = 1; irq_req = 1;
    run("R3", 0);
    // R3: fast masked, normal taken
    setup(2'd0, 0, 4'h0, 99); scr[0] = 2'd0; fiq_req = 1; fiq_mask = 1; irq_req = 1;
    run("R3", 0);
    // R3: both masked, transfer completes
    setup(2'd1, 0, 4'h0, 99); scr[0] = 2'd0; fiq_req = 1; fiq_mask = 1; irq_req = 1; irq_mask = 1;
    cp_rdata = 32'h7777_1111;
    run("R3 R10", 0);
    // R6: coprocessor stays busy until the limit
    setup(2'd0, 0, 4'h0, 99); for (int i = 0; i < 16; i++) scr[i] = 2'd0;
    run("R6", 0);
    // R7 R8 R12: three-word load with writeback
    setup(2'd2, 1, 4'h0, 99); addr_in = 32'h100; scr[0] = 2'd2; scr[1] = 2'd3; scr[2] = 2'd3; scr[3] = 2'd2;
    run("R7 R8 R12", 0);
    // R1 R7 R12: one-word store after busy, second start ignored
    setup(2'd3, 0, 4'h0, 99); addr_in = 32'h2000; scr[0] = 2'd0; scr[1] = 2'd2; scr[2] = 2'd2;
    cp_rdata = 32'hDEAD_BEEF;
    run("R1 R7 R12", 1);
    // R9 R8: abort on the middle word of a load, burst continues
    setup(2'd2, 1, 4'h0, 1); addr_in = 32'h40; scr[0] = 2'd2; scr[1] = 2'd3; scr[2] = 2'd3; scr[3] = 2'd2;
    run("R9 R8", 0);
    // R5: store refused at first phase
    setup(2'd3, 0, 4'h3, 99); scr[0] = 2'd1;
    run("R5", 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule